// File: doc/BRIEF.md
# Next-PC and Branch Resolution Unit

This block decides where a 32-bit, word-addressed RISC core fetches next. Each cycle that a decoded instruction is offered with its program counter, the two register operands it names and the current return, debug-return and exception-return addresses, the unit works out the following program counter. It also works out whether a link register must be written, and with what, and whether the saved status word must be copied back into the live status register.

Control transfers come in five kinds. There are absolute jumps inside the current 256 MB region, with or without a call link. There are PC-relative branches, either unconditional or guarded by one of six signed or unsigned comparisons. There are jumps and calls through a register. There are returns through the return-address, debug-return or exception-return register. Finally, an instruction can read its own successor address into a register. Every other instruction falls through to PC+4. Results are registered and appear one clock after the request, together with a single-cycle `taken` flag that a pipeline can use to flush.

Top module: `npc_resolve_unit`

## Requirements
- R1: While reset is low, and in the first cycle after it, outValid, taken, linkWe and statusWe are all 0.
- R2: Primary opcode instr[5:0]=0x01 gives nextPc = {pc[31:28], instr[31:6], 2'b00} and writes no link.
- R3: Opcode 0x00 gives the same target as R2 and also writes pc+4 to register 31 (linkIdx=31, linkData=pc+4).
- R4: Opcode 0x06 gives nextPc = pc+4+sext(instr[21:6]) with offset bits [1:0] cleared.
- R5: Opcodes 0x0E bge, 0x16 blt, 0x1E bne, 0x26 beq, 0x2E bgeu and 0x36 bltu compare A (index instr[31:27]) with B (index instr[26:22]). They go to the R4 target when the comparison holds and to pc+4 when it does not.
- R6: An operand whose register index is 0 is taken as zero, whatever value arrives on its operand port.
- R7: With opcode 0x3A and extended opcode instr[16:11], 0x05 loads nextPc from raVal, 0x09 loads it from baVal, and 0x01 loads it from eaVal and pulses statusWe with statusData=estatusVal.
- R8: Extended opcode 0x0D loads nextPc from A. Extended opcode 0x1D does the same and also writes pc+4 to register 31.
- R9: Extended opcode 0x1C writes pc+4 to register instr[21:17] and continues at pc+4. No link write is made when the index is 0.
- R10: taken is 1 exactly when an output is valid and nextPc differs from that request's pc+4.
- R11: Any other primary or extended opcode continues at pc+4 with no link write and no status restore.
- R12: Results appear one cycle after inValid. In a cycle that follows one without inValid, outValid, taken, linkWe and statusWe are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request valid this cycle |
| pc | input | 32 | Address of the instruction |
| instr | input | 32 | Instruction word |
| opA | input | 32 | Value of the register at index instr[31:27] |
| opB | input | 32 | Value of the register at index instr[26:22] |
| raVal | input | 32 | Return-address register |
| baVal | input | 32 | Debug-return address register |
| eaVal | input | 32 | Exception-return address register |
| estatusVal | input | 32 | Saved status word |
| outValid | output | 1 | Registered result valid |
| nextPc | output | 32 | Next fetch address |
| taken | output | 1 | Flow left the sequential path |
| linkWe | output | 1 | Link register write strobe |
| linkIdx | output | 5 | Link destination index |
| linkData | output | 32 | Link value (pc+4) |
| statusWe | output | 1 | Status restore strobe |
| statusData | output | 32 | Value to copy into status |

## Verification
The bench aims at the cases a branch unit most often gets wrong. Signed and unsigned comparisons are driven with operands that differ only in the sign bit; a design that mixed the two kinds up would take bltu where it should take blt. Branch offsets are made negative with nonzero low bits, which catches a missing sign extension or missing alignment. Absolute jumps are issued from high-region PCs, where a lost region field would send the core to the bottom of memory. Operands at index 0 carry nonzero port values, and nextpc is aimed at register 0; a design that let either through would corrupt the register file.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int unsigned OPC_W = 6;

  localparam logic [OPC_W-1:0] OPC_CALL  = 6'h00;
  localparam logic [OPC_W-1:0] OPC_JABS  = 6'h01;
  localparam logic [OPC_W-1:0] OPC_BRU   = 6'h06;
  localparam logic [OPC_W-1:0] OPC_BGE   = 6'h0E;
  localparam logic [OPC_W-1:0] OPC_BLT   = 6'h16;
  localparam logic [OPC_W-1:0] OPC_BNE   = 6'h1E;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h26;
  localparam logic [OPC_W-1:0] OPC_BGEU  = 6'h2E;
  localparam logic [OPC_W-1:0] OPC_BLTU  = 6'h36;
  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'h3A;

  localparam logic [OPC_W-1:0] XOP_ERET  = 6'h01;
  localparam logic [OPC_W-1:0] XOP_RET   = 6'h05;
  localparam logic [OPC_W-1:0] XOP_BRET  = 6'h09;
  localparam logic [OPC_W-1:0] XOP_JMPR  = 6'h0D;
  localparam logic [OPC_W-1:0] XOP_NXPC  = 6'h1C;
  localparam logic [OPC_W-1:0] XOP_CALLR = 6'h1D;

  typedef enum logic [2:0] {
    SRC_SEQ,
    SRC_ABS,
    SRC_REL,
    SRC_RA,
    SRC_BA,
    SRC_EA,
    SRC_OPA
  } pcSrc_e;

  typedef enum logic [2:0] {
    CMP_ALWAYS,
    CMP_GE,
    CMP_LT,
    CMP_NE,
    CMP_EQ,
    CMP_GEU,
    CMP_LTU
  } cmpKind_e;

  typedef enum logic {
    LNK_RA,
    LNK_RC
  } linkDst_e;

  typedef struct packed {
    pcSrc_e   pcSrc;
    cmpKind_e cmpKind;
    logic     linkEn;
    linkDst_e linkDst;
    logic     statusRestore;
  } ctrl_t;
endpackage

// File: rtl/npc_ctrl.sv
module npc_ctrl
  import npc_pkg::*;
(
  input  logic [31:0] instr,
  output ctrl_t       ctrl
);
  logic [OPC_W-1:0] opc;
  logic [OPC_W-1:0] xop;

  assign opc = instr[5:0];
  assign xop = instr[16:11];

  always_comb begin
    ctrl = '{pcSrc: SRC_SEQ, cmpKind: CMP_ALWAYS, linkEn: 1'b0,
             linkDst: LNK_RA, statusRestore: 1'b0};
    unique case (opc)
      OPC_CALL: begin
        ctrl.pcSrc  = SRC_ABS;
        ctrl.linkEn = 1'b1;
      end
      OPC_JABS: ctrl.pcSrc = SRC_ABS;
      OPC_BRU:  ctrl.pcSrc = SRC_REL;
      OPC_BGE:  begin ctrl.pcSrc = SRC_REL; ctrl.cmpKind = CMP_GE;  end
      OPC_BLT:  begin ctrl.pcSrc = SRC_REL; ctrl.cmpKind = CMP_LT;  end
      OPC_BNE:  begin ctrl.pcSrc = SRC_REL; ctrl.cmpKind = CMP_NE;  end
      OPC_BEQ:  begin ctrl.pcSrc = SRC_REL; ctrl.cmpKind = CMP_EQ;  end
      OPC_BGEU: begin ctrl.pcSrc = SRC_REL; ctrl.cmpKind = CMP_GEU; end
      OPC_BLTU: begin ctrl.pcSrc = SRC_REL; ctrl.cmpKind = CMP_LTU; end
      OPC_RTYPE: begin
        unique case (xop)
          XOP_ERET: begin
            ctrl.pcSrc         = SRC_EA;
            ctrl.statusRestore = 1'b1;
          end
          XOP_RET:  ctrl.pcSrc = SRC_RA;
          XOP_BRET: ctrl.pcSrc = SRC_BA;
          XOP_JMPR: ctrl.pcSrc = SRC_OPA;
          XOP_NXPC: begin
            ctrl.linkEn  = 1'b1;
            ctrl.linkDst = LNK_RC;
          end
          XOP_CALLR: begin
            ctrl.pcSrc  = SRC_OPA;
            ctrl.linkEn = 1'b1;
          end
          default: ;
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/npc_datapath.sv
module npc_datapath
  import npc_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned IDX_W       = 5,
  parameter int unsigned REGION_W    = 4,
  parameter int unsigned LINK_REG    = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] pc,
  input  logic [DATA_W-1:0] instr,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] raVal,
  input  logic [DATA_W-1:0] baVal,
  input  logic [DATA_W-1:0] eaVal,
  input  logic [DATA_W-1:0] estatusVal,
  output logic              outValid,
  output logic [DATA_W-1:0] nextPc,
  output logic              taken,
  output logic              linkWe,
  output logic [IDX_W-1:0]  linkIdx,
  output logic [DATA_W-1:0] linkData,
  output logic              statusWe,
  output logic [DATA_W-1:0] statusData
);
  localparam int unsigned IMM16_W = 16;
  localparam int unsigned IMM26_W = DATA_W - 6;
  localparam int unsigned ABS_LOW = DATA_W - REGION_W;

  logic [IDX_W-1:0]  idxA, idxB, idxC;
  logic [DATA_W-1:0] valA, valB;
  logic [DATA_W-1:0] seqPc, relPc, absPc, selPc;
  logic [DATA_W-1:0] relOff;
  logic [IMM26_W+1:0] absLow;
  logic              condOk;
  logic [IDX_W-1:0]  dstIdx;

  assign idxA = instr[31:27];
  assign idxB = instr[26:22];
  assign idxC = instr[21:17];

  // index 0 is hard-wired to zero
  assign valA = (idxA == '0) ? '0 : opA;
  assign valB = (idxB == '0) ? '0 : opB;

  assign seqPc  = pc + DATA_W'(4);
  assign relOff = {{(DATA_W-IMM16_W){instr[21]}}, instr[21:8], 2'b00};
  assign relPc  = seqPc + relOff;
  assign absLow = {instr[DATA_W-1:6], 2'b00};
  assign absPc  = {pc[DATA_W-1:ABS_LOW], absLow[ABS_LOW-1:0]};

  always_comb begin
    unique case (ctrl.cmpKind)
      CMP_ALWAYS: condOk = 1'b1;
      CMP_GE:     condOk = $signed(valA) >= $signed(valB);
      CMP_LT:     condOk = $signed(valA) <  $signed(valB);
      CMP_NE:     condOk = valA != valB;
      CMP_EQ:     condOk = valA == valB;
      CMP_GEU:    condOk = valA >= valB;
      CMP_LTU:    condOk = valA <  valB;
      default:    condOk = 1'b0;
    endcase
  end

  always_comb begin
    unique case (ctrl.pcSrc)
      SRC_ABS: selPc = absPc;
      SRC_REL: selPc = condOk ? relPc : seqPc;
      SRC_RA:  selPc = raVal;
      SRC_BA:  selPc = baVal;
      SRC_EA:  selPc = eaVal;
      SRC_OPA: selPc = valA;
      default: selPc = seqPc;
    endcase
  end

  assign dstIdx = (ctrl.linkDst == LNK_RC) ? idxC : IDX_W'(LINK_REG);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      taken      <= 1'b0;
      linkWe     <= 1'b0;
      statusWe   <= 1'b0;
      nextPc     <= '0;
      linkIdx    <= '0;
      linkData   <= '0;
      statusData <= '0;
    end else begin
      outValid <= inValid;
      taken    <= inValid && (selPc != seqPc);
      linkWe   <= inValid && ctrl.linkEn && (dstIdx != '0);
      statusWe <= inValid && ctrl.statusRestore;
      if (inValid) begin
        nextPc     <= selPc;
        linkIdx    <= dstIdx;
        linkData   <= seqPc;
        statusData <= estatusVal;
      end
    end
  end
endmodule

// File: rtl/npc_resolve_unit.sv
module npc_resolve_unit
  import npc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] pc,
  input  logic [31:0] instr,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic [31:0] raVal,
  input  logic [31:0] baVal,
  input  logic [31:0] eaVal,
  input  logic [31:0] estatusVal,
  output logic        outValid,
  output logic [31:0] nextPc,
  output logic        taken,
  output logic        linkWe,
  output logic [4:0]  linkIdx,
  output logic [31:0] linkData,
  output logic        statusWe,
  output logic [31:0] statusData
);
  ctrl_t ctrl;

  npc_ctrl i_ctrl (
    .instr (instr),
    .ctrl  (ctrl)
  );

  npc_datapath #(
    .DATA_W   (32),
    .IDX_W    (5),
    .REGION_W (4),
    .LINK_REG (31)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .ctrl       (ctrl),
    .pc         (pc),
    .instr      (instr),
    .opA        (opA),
    .opB        (opB),
    .raVal      (raVal),
    .baVal      (baVal),
    .eaVal      (eaVal),
    .estatusVal (estatusVal),
    .outValid   (outValid),
    .nextPc     (nextPc),
    .taken      (taken),
    .linkWe     (linkWe),
    .linkIdx    (linkIdx),
    .linkData   (linkData),
    .statusWe   (statusWe),
    .statusData (statusData)
  );
endmodule

// File: rtl/npc_resolve_chk.sv
module npc_resolve_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic        outValid,
  input logic [31:0] nextPc,
  input logic        taken,
  input logic        linkWe,
  input logic [4:0]  linkIdx,
  input logic        statusWe
);
  // R12
  out_follows_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid && !taken && !linkWe && !statusWe);

  // R10
  taken_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (taken == (nextPc != $past(pc) + 32'd4)));

  // R9
  no_zero_link_chk: assert property (@(posedge clk) disable iff (!rstN)
    linkWe |-> linkIdx != 5'd0);

  // R2
  region_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && instr[5:0] == 6'h01) |=> nextPc[31:28] == $past(pc[31:28]));

  // R7
  restore_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusWe |-> outValid && !linkWe);
endmodule

bind npc_resolve_unit npc_resolve_chk i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .pc       (pc),
  .instr    (instr),
  .outValid (outValid),
  .nextPc   (nextPc),
  .taken    (taken),
  .linkWe   (linkWe),
  .linkIdx  (linkIdx),
  .statusWe (statusWe)
);

// File: tb/test_npc_resolve_unit.sv
module test_npc_resolve_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] pc = '0, instr = '0, opA = '0, opB = '0;
  logic [31:0] raVal = '0, baVal = '0, eaVal = '0, estatusVal = '0;
  logic        outValid, taken, linkWe, statusWe;
  logic [31:0] nextPc, linkData, statusData;
  logic [4:0]  linkIdx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  npc_resolve_unit i_npc_resolve_unit (.*);

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  typedef struct {
    logic [31:0] npc;
    logic        tk;
    logic        lwe;
    logic [4:0]  lidx;
    logic [31:0] ldat;
    logic        swe;
    logic [31:0] sdat;
    string       req;
  } exp_t;

  function automatic exp_t model(logic [31:0] p, logic [31:0] i, logic [31:0] a,
                                 logic [31:0] b, logic [31:0] ra, logic [31:0] ba,
                                 logic [31:0] ea, logic [31:0] es);
    exp_t e;
    logic [31:0] va, vb, seq, rel;
    logic [5:0] op, xo;
    logic cnd;
    op  = i[5:0];
    xo  = i[16:11];
    va  = (i[31:27] == 0) ? 32'd0 : a;
    vb  = (i[26:22] == 0) ? 32'd0 : b;
    seq = p + 4;
    rel = seq + ({{16{i[21]}}, i[21:6]} & 32'hFFFF_FFFC);
    e.npc = seq; e.lwe = 0; e.lidx = 5'd31; e.ldat = seq; e.swe = 0; e.sdat = es;
    e.req = "R11";
    cnd = 0;
    case (op)
      6'h00: begin e.npc = {p[31:28], i[31:6], 2'b00}; e.lwe = 1; e.req = "R3"; end
      6'h01: begin e.npc = {p[31:28], i[31:6], 2'b00}; e.req = "R2"; end
      6'h06: begin e.npc = rel; e.req = "R4"; end
      6'h0E, 6'h16, 6'h1E, 6'h26, 6'h2E, 6'h36: begin
        case (op)
          6'h0E: cnd = $signed(va) >= $signed(vb);
          6'h16: cnd = $signed(va) <  $signed(vb);
          6'h1E: cnd = va != vb;
          6'h26: cnd = va == vb;
          6'h2E: cnd = va >= vb;
          default: cnd = va < vb;
        endcase
        e.npc = cnd ? rel : seq; e.req = "R5";
      end
      6'h3A: begin
        case (xo)
          6'h01: begin e.npc = ea; e.swe = 1; e.req = "R7"; end
          6'h05: begin e.npc = ra; e.req = "R7"; end
          6'h09: begin e.npc = ba; e.req = "R7"; end
          6'h0D: begin e.npc = va; e.req = "R8"; end
          6'h1D: begin e.npc = va; e.lwe = 1; e.req = "R8"; end
          6'h1C: begin e.lidx = i[21:17]; e.lwe = (i[21:17] != 0); e.req = "R9"; end
          default: ;
        endcase
      end
      default: ;
    endcase
    e.tk = (e.npc != seq);
    return e;
  endfunction

  task automatic issue(input logic [31:0] p, input logic [31:0] i,
                       input logic [31:0] a, input logic [31:0] b);
    exp_t e;
    @(negedge clk);
    pc = p; instr = i; opA = a; opB = b;
    raVal = $urandom; baVal = $urandom; eaVal = $urandom; estatusVal = $urandom;
    inValid = 1'b1;
    e = model(p, i, a, b, raVal, baVal, eaVal, estatusVal);
    @(negedge clk);
    inValid = 1'b0;
    chk("R12", "outValid", 32'(outValid), 32'd1);
    chk(e.req, "nextPc", nextPc, e.npc);
    chk("R10", "taken", 32'(taken), 32'(e.tk));
    chk(e.req, "linkWe", 32'(linkWe), 32'(e.lwe));
    if (e.lwe) begin
      chk(e.req, "linkIdx", 32'(linkIdx), 32'(e.lidx));
      chk(e.req, "linkData", linkData, e.ldat);
    end
    chk(e.req, "statusWe", 32'(statusWe), 32'(e.swe));
    if (e.swe) chk("R7", "statusData", statusData, e.sdat);
  endtask

  function automatic logic [31:0] mkI(logic [4:0] ra_, logic [4:0] rb_,
                                      logic [15:0] imm, logic [5:0] op);
    return {ra_, rb_, imm, op};
  endfunction

  function automatic logic [31:0] mkR(logic [4:0] ra_, logic [4:0] rc,
                                      logic [5:0] xo);
    return {ra_, 5'd3, rc, xo, 5'd0, 6'h3A};
  endfunction

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [5:0] ops [12];
    logic [5:0] xops [8];
    void'($urandom(32'd1234));
    ops = '{6'h00, 6'h01, 6'h06, 6'h0E, 6'h16, 6'h1E, 6'h26, 6'h2E, 6'h36,
            6'h3A, 6'h04, 6'h3F};
    xops = '{6'h01, 6'h05, 6'h09, 6'h0D, 6'h1C, 6'h1D, 6'h31, 6'h00};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "outValid", 32'(outValid), 0);
    chk("R1", "taken", 32'(taken), 0);
    chk("R1", "linkWe", 32'(linkWe), 0);
    chk("R1", "statusWe", 32'(statusWe), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "post-reset outValid", 32'(outValid), 0);

    // R2 / R3: absolute jump from a high region
    issue(32'hF000_1000, {26'h3FF_FFFF, 6'h01}, 0, 0);
    issue(32'h9ABC_0000, {26'h000_1234, 6'h00}, 0, 0);
    // R4: negative offset with low bits set
    issue(32'h0000_8000, mkI(0, 0, 16'hFFF3, 6'h06), 0, 0);
    // R5: sign-bit-only difference, signed vs unsigned
    issue(32'h100, mkI(5'd1, 5'd2, 16'h0040, 6'h16), 32'h8000_0000, 32'h1);
    issue(32'h100, mkI(5'd1, 5'd2, 16'h0040, 6'h36), 32'h8000_0000, 32'h1);
    issue(32'h100, mkI(5'd1, 5'd2, 16'h0040, 6'h0E), 32'h8000_0000, 32'h1);
    issue(32'h100, mkI(5'd1, 5'd2, 16'h0040, 6'h2E), 32'h8000_0000, 32'h1);
    // R6: index 0 operands read zero despite port values
    issue(32'h200, mkI(5'd0, 5'd0, 16'h0010, 6'h26), 32'h55, 32'hAA);
    issue(32'h200, mkR(5'd0, 5'd0, 6'h0D), 32'h1234_5678, 0);
    // R7 eret with status restore, R9 nextpc to r0 and to r7
    issue(32'h300, mkR(5'd4, 5'd0, 6'h01), 0, 0);
    issue(32'h300, mkR(5'd4, 5'd0, 6'h1C), 0, 0);
    issue(32'h300, mkR(5'd4, 5'd7, 6'h1C), 0, 0);
    // R8 callr
    issue(32'h400, mkR(5'd9, 5'd0, 6'h1D), 32'h0000_ABC0, 0);
    // R11 unrelated opcodes
    issue(32'h500, mkI(5'd1, 5'd2, 16'h7FFF, 6'h04), 1, 2);
    issue(32'h500, mkR(5'd1, 5'd2, 6'h31), 1, 2);

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [31:0] ins, a, b;
      ins = $urandom;
      ins[5:0] = ops[$urandom_range(0, 11)];
      if (ins[5:0] == 6'h3A) ins[16:11] = xops[$urandom_range(0, 7)];
      a = $urandom; b = ($urandom_range(0, 3) == 0) ? a : $urandom;
      if ($urandom_range(0, 7) == 0) ins[31:27] = 0;
      issue($urandom & 32'hFFFF_FFFC, ins, a, b);
      if ($urandom_range(0, 3) == 0) begin
        @(negedge clk);
        // R12 idle cycle
        chk("R12", "idle outValid", 32'(outValid), 0);
        chk("R12", "idle taken", 32'(taken), 0);
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule